// File: doc/BRIEF.md
# Channel start hold-off controller

This block decides when a single receive channel leaves sleep and begins processing. A start can come from a software strobe, from any of four asynchronous sync pins, or from software clearing the sleep bit. Each trigger source has an enable qualifier, except the sleep-clear path, which is always armed. A qualified trigger copies a 16-bit hold-off preload into a down-counter. When that counter expires, the channel becomes active and a one-cycle initialise pulse tells downstream logic to apply its configuration.

The hold-off delay lets several channels, or several devices, be brought up on the same sample even though their triggers arrive at different times. A trigger that arrives while the channel is already running reloads the counter, and a fresh initialise pulse follows when the count expires. This is used to realign timing. A preload of zero defeats the start. While the sleep bit is high the channel is held dormant and its configuration may be rewritten. The block takes no AGC sync input.

Top module: `chan_wake_ctrl`

## Requirements
- R1: After a synchronous reset, `chan_active_o` and `init_pulse_o` are 0 and `cfg_write_ok_o` is 1.
- R2: If `soft_sync_i` is high at a clock edge while `soft_en_i` is 1 and `sleep_i` is 0, and the preload N is nonzero, then `init_pulse_o` and `chan_active_o` rise on the edge N clocks later. If `soft_en_i` is 0, the strobe has no effect.
- R3: External sync pins pass through a two-flop synchroniser and are detected on their rising edge. A pin whose bit in `pin_en_i` is 1 loads the counter on the third clock edge after it goes high. A pin held high triggers only once. A pin whose enable bit is 0 is ignored.
- R4: While `sleep_i` is 1, each clock edge forces `chan_active_o` and `init_pulse_o` to 0 and cancels any pending count. All sync triggers are ignored while `sleep_i` is 1.
- R5: When `sleep_i` goes from 1 to 0, the block issues an internal start on the first edge that samples it low. This start uses the same preload and timing as a software sync and does not depend on `soft_en_i`.
- R6: A qualified trigger that finds a preload of 0 cancels any pending count, produces no initialise pulse, and leaves `chan_active_o` unchanged.
- R7: A qualified trigger that arrives while the channel is counting or already active reloads the counter. Only one initialise pulse follows, at the new expiry, and `chan_active_o` stays high throughout.
- R8: `cfg_write_ok_o` is 1 exactly when `chan_active_o` is 0.
- R9: `init_pulse_o` lasts one clock per expiry and never occurs while `chan_active_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_sync_i | input | 1 | Software sync strobe, active high |
| soft_en_i | input | 1 | Qualifier for the software strobe |
| pin_sync_i | input | 4 | Asynchronous external sync pins |
| pin_en_i | input | 4 | Per-pin qualifier |
| sleep_i | input | 1 | Sleep bit; 1 holds the channel asleep, a 1-to-0 change starts it |
| holdoff_i | input | 16 | Start hold-off preload; 0 defeats start |
| chan_active_o | output | 1 | Channel is awake and processing |
| init_pulse_o | output | 1 | One-cycle pulse to apply channel configuration |
| cfg_write_ok_o | output | 1 | Configuration may be rewritten safely |

## Verification
The start path is driven in three ways: by clearing sleep, by a software strobe, and by a single held pin. Each one predicts a different count of clock edges from stimulus to initialise pulse, so a latency error in one source cannot hide behind another. Disabled qualifiers, a disabled pin and strobes issued during sleep must each produce no pulse, which separates the qualification logic from the counter. Reload in the middle of a count, a zero preload while active, sleep asserted during a count, and a preload of one cover the counter's edge cases: cancelled expiries, unchanged activity and the shortest delay.

// File: rtl/chan_wake_pkg.sv
package chan_wake_pkg;

    // Channel state carried by the hold-off counter
    typedef struct packed {
        logic active;
        logic init;
    } chan_st_t;

    localparam chan_st_t ST_ASLEEP = '{active: 1'b0, init: 1'b0};

    // State after one counting step; expiry wakes and initialises
    function automatic chan_st_t step_state(chan_st_t cur, logic expire);
        chan_st_t nxt;
        nxt.active = cur.active | expire;
        nxt.init   = expire;
        return nxt;
    endfunction

endpackage

// File: rtl/pin_edge_sync.sv
module pin_edge_sync #(
    parameter int NUM_PINS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_i,
    output logic [NUM_PINS-1:0] rise_o
);
    logic [NUM_PINS-1:0] meta_q, stab_q, last_q;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q[p] <= 1'b0;
                stab_q[p] <= 1'b0;
                last_q[p] <= 1'b0;
            end else begin
                meta_q[p] <= pin_i[p];
                stab_q[p] <= meta_q[p];
                last_q[p] <= stab_q[p];
            end
        end
        assign rise_o[p] = stab_q[p] & ~last_q[p];
    end

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (|rise_o) |=> ((rise_o & $past(rise_o)) == '0)); // R3

endmodule

// File: rtl/start_qualifier.sv
module start_qualifier #(
    parameter int NUM_PINS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                soft_sync_i,
    input  logic                soft_en_i,
    input  logic [NUM_PINS-1:0] pin_rise_i,
    input  logic [NUM_PINS-1:0] pin_en_i,
    input  logic                sleep_i,
    output logic                fire_o
);
    logic sleep_q;
    logic wake_cmd;

    always_ff @(posedge clk) begin
        if (rst) sleep_q <= 1'b1;
        else     sleep_q <= sleep_i;
    end

    assign wake_cmd = sleep_q & ~sleep_i;
    assign fire_o   = ~sleep_i & (wake_cmd
                                  | (soft_sync_i & soft_en_i)
                                  | (|(pin_rise_i & pin_en_i)));

    AST_SLEEP_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        sleep_i |-> !fire_o); // R4
    AST_WAKE_FIRES: assert property (@(posedge clk) disable iff (rst)
        ($past(sleep_i) && !sleep_i) |-> fire_o); // R5

endmodule

// File: rtl/holdoff_counter.sv
module holdoff_counter
    import chan_wake_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire_i,
    input  logic             sleep_i,
    input  logic [CNT_W-1:0] preload_i,
    output chan_st_t         st_o
);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic [CNT_W-1:0] cnt_q;
    chan_st_t         st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= ZERO;
            st_q  <= ST_ASLEEP;
        end else if (sleep_i) begin
            cnt_q <= ZERO;
            st_q  <= ST_ASLEEP;
        end else if (fire_i) begin
            cnt_q   <= preload_i;
            st_q.init <= 1'b0;
        end else if (cnt_q != ZERO) begin
            cnt_q <= cnt_q - ONE;
            st_q  <= step_state(st_q, cnt_q == ONE);
        end else begin
            st_q.init <= 1'b0;
        end
    end

    assign st_o = st_q;

    AST_LOAD_PRELOAD: assert property (@(posedge clk) disable iff (rst)
        (fire_i && !sleep_i && preload_i != ZERO) |=> (cnt_q == $past(preload_i))); // R7
    AST_ZERO_NO_WAKE: assert property (@(posedge clk) disable iff (rst)
        (fire_i && !sleep_i && preload_i == ZERO) |=> (!st_q.init && st_q.active == $past(st_q.active))); // R6
    AST_SLEEP_DROPS: assert property (@(posedge clk) disable iff (rst)
        sleep_i |=> (!st_q.active && !st_q.init)); // R4
    AST_INIT_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        st_q.init |-> st_q.active); // R9
    AST_RISE_HAS_INIT: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.active) |-> st_q.init); // R2

endmodule

// File: rtl/chan_wake_ctrl.sv
module chan_wake_ctrl
    import chan_wake_pkg::*;
#(
    parameter int NUM_PINS = 4,
    parameter int CNT_W    = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                soft_sync_i,
    input  logic                soft_en_i,
    input  logic [NUM_PINS-1:0] pin_sync_i,
    input  logic [NUM_PINS-1:0] pin_en_i,
    input  logic                sleep_i,
    input  logic [CNT_W-1:0]    holdoff_i,
    output logic                chan_active_o,
    output logic                init_pulse_o,
    output logic                cfg_write_ok_o
);
    logic [NUM_PINS-1:0] pin_rise;
    logic                fire;
    chan_st_t            st;

    pin_edge_sync #(.NUM_PINS(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (pin_sync_i),
        .rise_o (pin_rise)
    );

    start_qualifier #(.NUM_PINS(NUM_PINS)) u_qual (
        .clk         (clk),
        .rst         (rst),
        .soft_sync_i (soft_sync_i),
        .soft_en_i   (soft_en_i),
        .pin_rise_i  (pin_rise),
        .pin_en_i    (pin_en_i),
        .sleep_i     (sleep_i),
        .fire_o      (fire)
    );

    holdoff_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .fire_i    (fire),
        .sleep_i   (sleep_i),
        .preload_i (holdoff_i),
        .st_o      (st)
    );

    assign chan_active_o  = st.active;
    assign init_pulse_o   = st.init;
    assign cfg_write_ok_o = ~st.active;

    AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        ($past(chan_active_o) && !$past(sleep_i)) |-> chan_active_o); // R7

endmodule

// File: tb/sim_chan_wake_ctrl.sv
module sim_chan_wake_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        soft_sync_i, soft_en_i, sleep_i;
    logic [3:0]  pin_sync_i, pin_en_i;
    logic [15:0] holdoff_i;
    logic        chan_active_o, init_pulse_o, cfg_write_ok_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int pulse_cnt = 0;
    int exp_q[$];

    always #5 clk = ~clk;

    chan_wake_ctrl u0 (.*);

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compares each initialise pulse with the scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (exp_q.size() > 0 && exp_q[0] < cyc) begin
                errors++; checks++;
                $display("FAIL R2 missed init pulse: actual none expected cycle %0d", exp_q[0]);
                void'(exp_q.pop_front());
            end
            if (init_pulse_o) begin
                pulse_cnt++;
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R9 unexpected init pulse: actual cycle %0d expected none", cyc);
                end else if (exp_q[0] != cyc) begin
                    errors++;
                    $display("FAIL R2 init pulse timing: actual cycle %0d expected %0d", cyc, exp_q[0]);
                    void'(exp_q.pop_front());
                end else begin
                    void'(exp_q.pop_front());
                end
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic soft_pulse(bit expect_init);
        if (expect_init) exp_q.push_back(cyc + int'(holdoff_i) + 1);
        soft_sync_i = 1'b1;
        tick(1);
        soft_sync_i = 1'b0;
    endtask

    initial begin
        #150000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base;
        rst = 1'b1; soft_sync_i = 0; soft_en_i = 0; sleep_i = 1;
        pin_sync_i = 0; pin_en_i = 0; holdoff_i = 0;
        tick(4);
        rst = 1'b0;
        tick(1);
        chk("R1 active after reset", chan_active_o, 0);
        chk("R1 init after reset", init_pulse_o, 0);
        chk("R1 cfg ok after reset", cfg_write_ok_o, 1);

        // R5: sleep clear with hold-off 5
        holdoff_i = 16'd5;
        exp_q.push_back(cyc + 6);
        sleep_i = 1'b0;
        tick(5);
        chk("R2 not active before expiry", chan_active_o, 0);
        chk("R8 cfg ok while counting", cfg_write_ok_o, 1);
        tick(1);
        chk("R5 active after wake", chan_active_o, 1);
        chk("R8 cfg blocked when active", cfg_write_ok_o, 0);
        tick(2);
        chk("R9 init one cycle", init_pulse_o, 0);

        // R7: resync while active
        soft_en_i = 1'b1; holdoff_i = 16'd3;
        base = pulse_cnt;
        soft_pulse(1);
        tick(2);
        chk("R7 active stays high during reload", chan_active_o, 1);
        tick(4);
        chk("R7 one pulse on resync", pulse_cnt - base, 1);

        // R2: disabled software qualifier
        soft_en_i = 1'b0;
        base = pulse_cnt;
        soft_pulse(0);
        tick(15);
        chk("R2 disabled soft strobe ignored", pulse_cnt - base, 0);

        // R3: enabled pin B (bit 1) held high
        pin_en_i = 4'b0010; holdoff_i = 16'd4;
        base = pulse_cnt;
        exp_q.push_back(cyc + 3 + 4);
        pin_sync_i[1] = 1'b1;
        tick(30);
        pin_sync_i[1] = 1'b0;
        chk("R3 held pin one trigger", pulse_cnt - base, 1);
        base = pulse_cnt;
        pin_sync_i[2] = 1'b1;
        tick(20);
        pin_sync_i[2] = 1'b0;
        chk("R3 disabled pin ignored", pulse_cnt - base, 0);
        tick(5);

        // R7: reload mid-count
        soft_en_i = 1'b1; holdoff_i = 16'd10;
        base = pulse_cnt;
        soft_pulse(1);
        tick(3);
        holdoff_i = 16'd6;
        exp_q.delete();
        soft_pulse(1);
        tick(12);
        chk("R7 reload gives single pulse", pulse_cnt - base, 1);

        // R6: zero preload while active cancels pending count
        holdoff_i = 16'd8;
        base = pulse_cnt;
        soft_pulse(1);
        tick(3);
        holdoff_i = 16'd0;
        exp_q.delete();
        soft_pulse(0);
        tick(15);
        chk("R6 zero preload no pulse", pulse_cnt - base, 0);
        chk("R6 zero preload active unchanged", chan_active_o, 1);

        // R4: sleep forces dormancy and ignores triggers
        sleep_i = 1'b1;
        tick(1);
        chk("R4 sleep drops active", chan_active_o, 0);
        chk("R8 cfg ok when asleep", cfg_write_ok_o, 1);
        holdoff_i = 16'd3;
        base = pulse_cnt;
        soft_pulse(0);
        tick(10);
        chk("R4 trigger ignored asleep", pulse_cnt - base, 0);

        // R6: wake with zero preload stays dormant
        holdoff_i = 16'd0;
        sleep_i = 1'b0;
        tick(15);
        chk("R6 zero preload stays asleep", chan_active_o, 0);

        // R4: sleep in the middle of a count cancels it
        holdoff_i = 16'd6;
        base = pulse_cnt;
        soft_pulse(1);
        tick(2);
        sleep_i = 1'b1;
        exp_q.delete();
        tick(10);
        chk("R4 sleep cancels count", pulse_cnt - base, 0);
        chk("R4 still dormant", chan_active_o, 0);

        // R2: shortest hold-off of one
        holdoff_i = 16'd1;
        base = pulse_cnt;
        exp_q.push_back(cyc + 2);
        sleep_i = 1'b0;
        tick(4);
        chk("R2 preload one wakes", chan_active_o, 1);
        chk("R2 preload one pulse", pulse_cnt - base, 1);

        tick(3);
        chk("R9 no pending expectations", exp_q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule